// File: doc/BRIEF.md
# DMA Channel Interrupt Register Unit

This block holds the interrupt state of one descriptor-driven DMA channel. The channel engine reports three kinds of completion as single-cycle pulses: an outbound descriptor finished with its interrupt flag set, an inbound descriptor finished with its interrupt flag set, and an inbound end of packet. Each pulse sets fixed bits in a sticky raw status register.

Software sees four word-sized registers through a 32-bit write port and a combinational read port, addressed by byte offset. It programs an enable mask, reads the raw status and the masked status, and clears raw bits by writing ones to an acknowledge register. The acknowledge register holds no state and always reads zero. One level-sensitive interrupt line is high while any unmasked raw bit is set.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset the mask and the raw status are zero, every register reads zero, and `irq_o` is low.
- R2: An `out_done_i` pulse sets raw status bit 2.
- R3: An `in_done_i` pulse sets raw status bits 0 and 1 together.
- R4: An `in_eop_i` pulse sets raw status bit 3.
- R5: A write to offset 0x8c stores all 32 bits of `wdata_i` as the mask. Reading 0x8c returns the mask.
- R6: Reading offset 0x98 returns raw status AND mask. Reading offset 0x94 returns the raw status.
- R7: A write to offset 0x90 clears every raw bit whose position is one in `wdata_i` and leaves the other bits unchanged. Reading 0x90 always returns zero.
- R8: From the clock edge that updates the mask or the raw status, `irq_o` is high exactly when raw status AND mask is nonzero.
- R9: If an event sets a bit in the same cycle as an acknowledge of that bit, the bit ends up set.
- R10: Writes to offsets 0x94 and 0x98 change neither the raw status nor the mask.
- R11: Raw bits are sticky. They stay set across later events and mask changes until they are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the accessed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| out_done_i | input | 1 | Outbound descriptor done with interrupt flag, one-cycle pulse |
| in_done_i | input | 1 | Inbound descriptor done with interrupt flag, one-cycle pulse |
| in_eop_i | input | 1 | Inbound end of packet, one-cycle pulse |
| irq_o | output | 1 | Level interrupt line |

## Verification
The hardest case to reach from the ports is an engine event that lands in the same clock cycle as an acknowledge covering that event's bit. Only in that cycle does set-over-clear priority decide whether an interrupt is lost. The bench drives an end-of-packet pulse and an all-ones acknowledge write in the same low phase of the clock. It then checks that the bit being acknowledged and re-raised survives, that an untouched acknowledged bit clears, and that the line stays high through the mask. Read-only offsets are written with all ones, then read back through the raw and masked offsets.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam logic [7:0] OFS_MASK   = 8'h8c;
  localparam logic [7:0] OFS_ACK    = 8'h90;
  localparam logic [7:0] OFS_RAW    = 8'h94;
  localparam logic [7:0] OFS_MASKED = 8'h98;

  // event -> raw bit positions
  localparam int unsigned BIT_IN_DONE_A = 0;
  localparam int unsigned BIT_IN_DONE_B = 1;
  localparam int unsigned BIT_OUT_DONE  = 2;
  localparam int unsigned BIT_IN_EOP    = 3;
  localparam int unsigned NUM_SRC_BITS  = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_ACK,
    SEL_RAW,
    SEL_MASKED
  } reg_sel_e;
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output reg_sel_e          sel_o,
  output logic              wr_mask_o,
  output logic              wr_ack_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_MASK):   sel_o = SEL_MASK;
      ADDR_W'(OFS_ACK):    sel_o = SEL_ACK;
      ADDR_W'(OFS_RAW):    sel_o = SEL_RAW;
      ADDR_W'(OFS_MASKED): sel_o = SEL_MASKED;
      default:             sel_o = SEL_NONE;
    endcase
  end

  assign wr_mask_o = wr_en_i && (sel_o == SEL_MASK);
  assign wr_ack_o  = wr_en_i && (sel_o == SEL_ACK);
endmodule

// File: rtl/dma_irq_raw.sv
module dma_irq_raw #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] raw_d_o,
  output logic [DATA_W-1:0] raw_q_o
);
  logic [DATA_W-1:0] raw_q;

  // set beats clear
  assign raw_d_o = (raw_q & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= raw_d_o;
  end

  assign raw_q_o = raw_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(set_i)) == $past(set_i)));
  // R7
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(clr_i & ~set_i)) == '0));
  // R11
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
endmodule

// File: rtl/dma_irq_line.sv
module dma_irq_line #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] raw_d_i,
  input  logic [DATA_W-1:0] raw_q_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] masked_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_q, mask_d;
  logic              irq_q;

  assign mask_d = wr_mask_i ? wdata_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(raw_d_i & mask_d);  // line follows next-state values
    end
  end

  assign mask_o   = mask_q;
  assign masked_o = raw_q_i & mask_q;
  assign irq_o    = irq_q;

  // R5
  mask_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> (mask_q == $past(wdata_i)));
  // R10
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_q));
  // R8
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == ((raw_q_i & mask_q) != '0));
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              out_done_i,
  input  logic              in_done_i,
  input  logic              in_eop_i,
  output logic              irq_o
);
  localparam int unsigned SRC_W = NUM_SRC_BITS;

  reg_sel_e          sel;
  logic              wr_mask, wr_ack;
  logic [DATA_W-1:0] set_vec, clr_vec, raw_d, raw_q, mask_q, masked;
  logic [SRC_W-1:0]  src_bits;

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .sel_o     (sel),
    .wr_mask_o (wr_mask),
    .wr_ack_o  (wr_ack)
  );

  assign src_bits[BIT_IN_DONE_A] = in_done_i;
  assign src_bits[BIT_IN_DONE_B] = in_done_i;
  assign src_bits[BIT_OUT_DONE]  = out_done_i;
  assign src_bits[BIT_IN_EOP]    = in_eop_i;

  for (genvar k = 0; k < DATA_W; k++) begin : g_set
    if (k < SRC_W) begin : g_src
      assign set_vec[k] = src_bits[k];
    end else begin : g_none
      assign set_vec[k] = 1'b0;
    end
  end

  // ack is write-only: acts for one cycle, nothing stored
  assign clr_vec = wr_ack ? wdata_i : '0;

  dma_irq_raw #(.DATA_W(DATA_W)) u_raw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .raw_d_o (raw_d),
    .raw_q_o (raw_q)
  );

  dma_irq_line #(.DATA_W(DATA_W)) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_mask_i (wr_mask),
    .wdata_i   (wdata_i),
    .raw_d_i   (raw_d),
    .raw_q_i   (raw_q),
    .mask_o    (mask_q),
    .masked_o  (masked),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_MASK:   rdata_o = mask_q;
      SEL_RAW:    rdata_o = raw_q;
      SEL_MASKED: rdata_o = masked;
      default:    rdata_o = '0;
    endcase
  end

  // R2
  out_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_done_i |=> raw_q[BIT_OUT_DONE]);
  // R3
  in_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_done_i |=> (raw_q[BIT_IN_DONE_A] && raw_q[BIT_IN_DONE_B]));
  // R4
  in_eop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_eop_i |=> raw_q[BIT_IN_EOP]);
  // R7
  ack_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_ACK) |-> (rdata_o == '0));
  // R10
  raw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ack && !out_done_i && !in_done_i && !in_eop_i) |=> $stable(raw_q));
endmodule

// File: tb/tb_dma_irq_regs.sv
`timescale 1ns/1ps
module tb_dma_irq_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        out_done_i = 1'b0, in_done_i = 1'b0, in_eop_i = 1'b0;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_MASK = 8'h8c, A_ACK = 8'h90, A_RAW = 8'h94, A_MSK = 8'h98;

  always #2.5 clk_i = ~clk_i;

  dma_irq_regs dut (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .out_done_i, .in_done_i, .in_eop_i, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive during low phase, take effect at next rising edge, sample at following falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic pulse(input bit od, input bit id, input bit ep);
    out_done_i = od; in_done_i = id; in_eop_i = ep;
    @(posedge clk_i); @(negedge clk_i);
    out_done_i = 1'b0; in_done_i = 1'b0; in_eop_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr_i = a; #0.1;
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 mask", A_MASK, 32'h0);
    rd_chk("R1 raw", A_RAW, 32'h0);
    rd_chk("R1 masked", A_MSK, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_mask_rw;
    wr(A_MASK, 32'hA5A5_0000);
    rd_chk("R5 mask readback", A_MASK, 32'hA5A5_0000);
    chk("R8 irq no raw", {31'b0, irq_o}, 32'h0);
    wr(A_MASK, 32'h0);
    rd_chk("R5 mask cleared", A_MASK, 32'h0);
  endtask

  task automatic t_out_done;
    pulse(1, 0, 0);
    rd_chk("R2 raw bit2", A_RAW, 32'h4);
    rd_chk("R6 masked zero", A_MSK, 32'h0);
    chk("R8 irq masked off", {31'b0, irq_o}, 32'h0);
    wr(A_MASK, 32'h4);
    chk("R8 irq on mask", {31'b0, irq_o}, 32'h1);
    rd_chk("R6 masked bit2", A_MSK, 32'h4);
    wr(A_ACK, 32'h4);
    rd_chk("R7 raw cleared", A_RAW, 32'h0);
    chk("R8 irq off after ack", {31'b0, irq_o}, 32'h0);
    rd_chk("R7 ack reads zero", A_ACK, 32'h0);
  endtask

  task automatic t_in_path;
    pulse(0, 1, 0);
    rd_chk("R3 raw bits0,1", A_RAW, 32'h3);
    pulse(0, 0, 1);
    rd_chk("R4 raw bit3 sticky R11", A_RAW, 32'hB);
    wr(A_MASK, 32'h8);
    rd_chk("R6 masked bit3", A_MSK, 32'h8);
    chk("R8 irq eop", {31'b0, irq_o}, 32'h1);
    wr(A_ACK, 32'h1);
    rd_chk("R7 partial ack", A_RAW, 32'hA);
    chk("R11 irq held", {31'b0, irq_o}, 32'h1);
    wr(A_ACK, 32'h8);
    rd_chk("R7 ack bit3", A_RAW, 32'h2);
    chk("R8 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_collision;
    // raw=0x2, mask=0x8; eop pulse and ack-all in the same cycle
    in_eop_i = 1'b1;
    wr(A_ACK, 32'hF);
    in_eop_i = 1'b0;
    rd_chk("R9 event beats ack", A_RAW, 32'h8);
    chk("R9 irq kept", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_readonly;
    wr(A_RAW, 32'hFFFF_FFFF);
    rd_chk("R10 raw write ignored", A_RAW, 32'h8);
    wr(A_MSK, 32'hFFFF_FFFF);
    rd_chk("R10 masked write raw", A_RAW, 32'h8);
    rd_chk("R10 masked write mask", A_MASK, 32'h8);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd_chk("R7 ack all", A_RAW, 32'h0);
    chk("R8 irq final", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mask_rw();
    t_out_done();
    t_in_path();
    t_collision();
    t_readonly();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule